// File: doc/BRIEF.md
# Channel-Interleaving Burst Splitter

This block breaks one linear copy request (source address, destination address, byte length) into a sequence of bursts that a multi-channel stacked-DRAM memory can serve efficiently. No burst is longer than 256 bytes. No burst crosses a 256-byte region boundary on either the source side or the destination side. When a transfer starts part-way into a region, the first burst is therefore shorter and ends at the nearer boundary.

Every burst carries a 4-bit channel index taken from a scrambled form of its source address. Consecutive full-size bursts of one transfer spread across all 16 channels, and no single channel becomes a hot spot. Requests enter on a valid/ready port. Bursts leave on a second valid/ready port that carries the source address, the destination address, the byte count, the channel index and a last flag. The splitter handles one transfer at a time.

Top module: `bsplit_top`

## Requirements
- R1: Every emitted burst has a byte count between 1 and 256 inclusive; the count is encoded as a plain binary number of bytes, so 256 is 9'h100.
- R2: No burst crosses a 256-byte boundary: the low 8 address bits plus the byte count is at most 256, for both the source and the destination address.
- R3: The first burst of a transfer ends at the nearer 256-byte boundary of source or destination, or at the end of the transfer if that comes first.
- R4: The channel index equals source address bits [11:8] XOR source address bits [15:12].
- R5: For a transfer whose source and destination are 256-byte aligned, the 16 full bursts that cover one 4 KiB-aligned source region use 16 different channels.
- R6: Bursts are contiguous: each burst starts where the previous one ended, on both addresses. The byte counts sum to the request length, and only the final burst has the last flag set.
- R7: A request of length zero is accepted and produces no burst.
- R8: req_ready is low from the acceptance of a non-zero request until the cycle after its last burst is handed off, and high again in that cycle.
- R9: While bst_valid is high and bst_ready is low, bst_valid stays high and every burst field holds its value.
- R10: After reset, bst_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Splitter can take a request |
| req_src | input | 32 | Transfer source byte address |
| req_dst | input | 32 | Transfer destination byte address |
| req_len | input | 16 | Transfer length in bytes |
| bst_valid | output | 1 | Burst valid |
| bst_ready | input | 1 | Downstream takes the burst |
| bst_src | output | 32 | Burst source byte address |
| bst_dst | output | 32 | Burst destination byte address |
| bst_bytes | output | 9 | Burst length in bytes (1 to 256) |
| bst_chan | output | 4 | Scrambled channel index |
| bst_last | output | 1 | Final burst of the transfer |

## Verification
The cursor registers feed the burst port directly. A wrong cursor address or remaining count therefore shows up in the very burst that follows, as a gap or overlap against the previous burst, as a byte count that crosses a boundary, or as a length sum that does not match. A wrong busy flag shows within one cycle as a burst with no request behind it, as a lost burst, or as req_ready rising too early. The bench stalls the burst port on a regular pattern, so a cursor that advances without a handshake breaks the hold check on the next cycle.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;
  typedef enum logic { ST_IDLE = 1'b0, ST_RUN = 1'b1 } bsplit_state_e;
endpackage

// File: rtl/bsplit_chan_hash.sv
module bsplit_chan_hash #(
  parameter int CH_W = 4
) (
  input  logic [2*CH_W-1:0] addr_bits,
  output logic [CH_W-1:0]   chan
);
  // Fold the upper nibble onto the region index to spread strides.
  for (genvar i = 0; i < CH_W; i++) begin : g_fold
    assign chan[i] = addr_bits[i] ^ addr_bits[CH_W+i];
  end
endmodule

// File: rtl/bsplit_size_calc.sv
module bsplit_size_calc #(
  parameter int OFS_W = 8,
  parameter int LEN_W = 16
) (
  input  logic [OFS_W-1:0] src_lo,
  input  logic [OFS_W-1:0] dst_lo,
  input  logic [LEN_W-1:0] rem,
  output logic [OFS_W:0]   bytes,
  output logic             last
);
  localparam logic [OFS_W:0] BURST = (OFS_W+1)'(1) << OFS_W;

  logic [OFS_W:0] room_src;
  logic [OFS_W:0] room_dst;
  logic [OFS_W:0] room;
  logic [OFS_W:0] rem_cap;

  always_comb begin
    room_src = BURST - {1'b0, src_lo};
    room_dst = BURST - {1'b0, dst_lo};
    room     = (room_src < room_dst) ? room_src : room_dst;
    rem_cap  = (rem > LEN_W'(BURST)) ? BURST : rem[OFS_W:0];
    bytes    = (rem_cap < room) ? rem_cap : room;
    last     = (LEN_W'(bytes) == rem);
  end
endmodule

// File: rtl/bsplit_top.sv
module bsplit_top #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int OFS_W  = 8,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_src,
  input  logic [ADDR_W-1:0] req_dst,
  input  logic [LEN_W-1:0]  req_len,
  output logic              bst_valid,
  input  logic              bst_ready,
  output logic [ADDR_W-1:0] bst_src,
  output logic [ADDR_W-1:0] bst_dst,
  output logic [OFS_W:0]    bst_bytes,
  output logic [CH_W-1:0]   bst_chan,
  output logic              bst_last
);
  import bsplit_pkg::*;

  localparam int HASH_LO = OFS_W;
  localparam int HASH_HI = OFS_W + 2*CH_W - 1;

  bsplit_state_e     state_q, state_d;
  logic [ADDR_W-1:0] src_q, src_d;
  logic [ADDR_W-1:0] dst_q, dst_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              accept, step, cur_en;
  logic [OFS_W:0]    chunk;
  logic              chunk_last;

  bsplit_size_calc #(.OFS_W(OFS_W), .LEN_W(LEN_W)) u_size (
    .src_lo (src_q[OFS_W-1:0]),
    .dst_lo (dst_q[OFS_W-1:0]),
    .rem    (rem_q),
    .bytes  (chunk),
    .last   (chunk_last)
  );

  bsplit_chan_hash #(.CH_W(CH_W)) u_hash (
    .addr_bits (src_q[HASH_HI:HASH_LO]),
    .chan      (bst_chan)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign bst_valid = (state_q == ST_RUN);
  assign bst_src   = src_q;
  assign bst_dst   = dst_q;
  assign bst_bytes = chunk;
  assign bst_last  = chunk_last;

  assign accept = req_valid && req_ready;
  assign step   = bst_valid && bst_ready;
  assign cur_en = accept || step;

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    dst_d   = dst_q;
    rem_d   = rem_q;
    if (accept) begin
      src_d = req_src;
      dst_d = req_dst;
      rem_d = req_len;
      if (req_len != '0) state_d = ST_RUN;
    end else if (step) begin
      src_d = src_q + ADDR_W'(chunk);
      dst_d = dst_q + ADDR_W'(chunk);
      rem_d = rem_q - LEN_W'(chunk);
      if (chunk_last) state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      rem_q <= '0;
    end else if (cur_en) begin
      src_q <= src_d;
      dst_q <= dst_d;
      rem_q <= rem_d;
    end
  end
endmodule

// File: rtl/bsplit_chk.sv
module bsplit_chk #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 8,
  parameter int CH_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              bst_valid,
  input logic              bst_ready,
  input logic [ADDR_W-1:0] bst_src,
  input logic [ADDR_W-1:0] bst_dst,
  input logic [OFS_W:0]    bst_bytes,
  input logic [CH_W-1:0]   bst_chan,
  input logic              bst_last
);
  localparam logic [OFS_W+1:0] BURST = (OFS_W+2)'(1) << OFS_W;

  // R1
  a_r1_bytes_range: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> (bst_bytes != '0) && ({1'b0, bst_bytes} <= BURST));

  // R2
  a_r2_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> (({2'b0, bst_src[OFS_W-1:0]} + {1'b0, bst_bytes}) <= BURST) &&
                  (({2'b0, bst_dst[OFS_W-1:0]} + {1'b0, bst_bytes}) <= BURST));

  // R6
  a_r6_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_valid && bst_ready && !bst_last) |=>
      bst_valid && (bst_src == $past(bst_src) + ADDR_W'($past(bst_bytes))) &&
      (bst_dst == $past(bst_dst) + ADDR_W'($past(bst_bytes))));

  // R8
  a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> !req_ready);

  // R8
  a_r8_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_valid && bst_ready && bst_last) |=> req_ready && !bst_valid);

  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_valid && !bst_ready) |=> bst_valid && $stable(bst_src) &&
      $stable(bst_dst) && $stable(bst_bytes) && $stable(bst_chan) && $stable(bst_last));
endmodule

bind bsplit_top bsplit_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .bst_valid (bst_valid),
  .bst_ready (bst_ready),
  .bst_src   (bst_src),
  .bst_dst   (bst_dst),
  .bst_bytes (bst_bytes),
  .bst_chan  (bst_chan),
  .bst_last  (bst_last)
);

// File: tb/tb_bsplit_top.sv
module tb_bsplit_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [31:0] req_src, req_dst;
  logic [15:0] req_len;
  logic        bst_valid, bst_ready;
  logic [31:0] bst_src, bst_dst;
  logic [8:0]  bst_bytes;
  logic [3:0]  bst_chan;
  logic        bst_last;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [15:0] chan_mask;
  logic        stall_hold;

  // {src, dst, len, bursts, first bytes, last bytes}
  localparam logic [119:0] VEC [NVEC] = '{
    {32'h0000_1000, 32'h0000_2000, 16'd1024, 8'd4, 16'd256, 16'd256},
    {32'h0000_1010, 32'h0000_3010, 16'd600,  8'd3, 16'd240, 16'd104},
    {32'h0000_0000, 32'h0000_0080, 16'd512,  8'd4, 16'd128, 16'd128},
    {32'h0000_20F0, 32'h0000_40F0, 16'd16,   8'd1, 16'd16,  16'd16},
    {32'h0000_0055, 32'h0000_0055, 16'd1,    8'd1, 16'd1,   16'd1},
    {32'h0000_00FF, 32'h0000_10FF, 16'd258,  8'd3, 16'd1,   16'd1},
    {32'h0000_3000, 32'h0000_5000, 16'd100,  8'd1, 16'd100, 16'd100},
    {32'h0000_FF00, 32'h0000_8000, 16'd512,  8'd2, 16'd256, 16'd256}
  };

  bsplit_top dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .req_len(req_len),
    .bst_valid(bst_valid), .bst_ready(bst_ready),
    .bst_src(bst_src), .bst_dst(bst_dst), .bst_bytes(bst_bytes),
    .bst_chan(bst_chan), .bst_last(bst_last)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [31:0] s, input logic [31:0] d,
                          input logic [15:0] len, input int exp_n,
                          input int exp_first, input int exp_last);
    logic [31:0] es, ed;
    int n, sum, lastb, guard;
    logic [31:0] h_src, h_dst;
    logic [8:0]  h_bytes;
    logic [3:0]  h_chan;
    logic        h_last;
    es = s; ed = d; n = 0; sum = 0; lastb = 0; guard = 0;
    stall_hold = 1'b0;
    h_src = '0; h_dst = '0; h_bytes = '0; h_chan = '0; h_last = 1'b0;
    req_valid = 1'b1; req_src = s; req_dst = d; req_len = len;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (len == 16'd0) begin
      for (int k = 0; k < 5; k++) begin
        check(!bst_valid, "R7", "burst after zero length", 32'(bst_valid), 0);
        check(req_ready, "R7", "ready after zero length", 32'(req_ready), 1);
        @(negedge clk);
      end
      return;
    end
    while (guard < 4000) begin
      guard++;
      if (stall_hold) begin
        check(bst_valid && bst_src == h_src && bst_dst == h_dst && bst_bytes == h_bytes &&
              bst_chan == h_chan && bst_last == h_last, "R9", "held src",
              longint'(bst_src), longint'(h_src));
      end
      bst_ready = ((cyc % 3) != 1);
      stall_hold = 1'b0;
      if (bst_valid) begin
        check(!req_ready, "R8", "req_ready while busy", 32'(req_ready), 0);
        if (!bst_ready) begin
          stall_hold = 1'b1;
          h_src = bst_src; h_dst = bst_dst; h_bytes = bst_bytes;
          h_chan = bst_chan; h_last = bst_last;
        end else begin
          check(bst_bytes >= 1 && bst_bytes <= 256, "R1", "bytes", bst_bytes, 256);
          check((32'(bst_src[7:0]) + 32'(bst_bytes)) <= 256 &&
                (32'(bst_dst[7:0]) + 32'(bst_bytes)) <= 256, "R2", "crossing src low",
                bst_src[7:0], 0);
          check(bst_chan == (bst_src[11:8] ^ bst_src[15:12]), "R4", "chan",
                bst_chan, bst_src[11:8] ^ bst_src[15:12]);
          check(bst_src == es && bst_dst == ed, "R6", "burst src", bst_src, es);
          if (n == 0)
            check(int'(bst_bytes) == exp_first, "R3", "first bytes", bst_bytes, exp_first);
          chan_mask[bst_chan] = 1'b1;
          es = es + 32'(bst_bytes);
          ed = ed + 32'(bst_bytes);
          sum += int'(bst_bytes);
          lastb = int'(bst_bytes);
          n++;
          if (bst_last) begin
            @(negedge clk);
            bst_ready = 1'b0;
            check(req_ready && !bst_valid, "R8", "ready after last", 32'(req_ready), 1);
            break;
          end
        end
      end
      @(negedge clk);
    end
    check(n == exp_n, "R6", "burst count", n, exp_n);
    check(sum == int'(len), "R6", "byte sum", sum, len);
    check(lastb == exp_last, "R6", "last bytes", lastb, exp_last);
  endtask

  initial begin
    req_valid = 1'b0; req_src = '0; req_dst = '0; req_len = '0;
    bst_ready = 1'b0; chan_mask = '0; stall_hold = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!bst_valid, "R10", "bst_valid in reset", 32'(bst_valid), 0);
    check(req_ready, "R10", "req_ready in reset", 32'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bst_valid && req_ready, "R10", "idle after reset", 32'(bst_valid), 0);

    for (int v = 0; v < NVEC; v++) begin
      run_xfer(VEC[v][119:88], VEC[v][87:56], VEC[v][55:40], int'(VEC[v][39:32]),
               int'(VEC[v][31:16]), int'(VEC[v][15:0]));
    end

    // R7: zero length request
    run_xfer(32'h0000_0400, 32'h0000_0800, 16'd0, 0, 0, 0);

    // R5: aligned 4 KiB region, upper nibble non-zero
    chan_mask = '0;
    run_xfer(32'h0000_7000, 32'h0001_0000, 16'd4096, 16, 256, 256);
    check(chan_mask == 16'hFFFF, "R5", "channel coverage", chan_mask, 16'hFFFF);

    // R5 again with upper nibble zero
    chan_mask = '0;
    run_xfer(32'h0002_0000, 32'h0003_0000, 16'd4096, 16, 256, 256);
    check(chan_mask == 16'hFFFF, "R5", "channel coverage zero fold", chan_mask, 16'hFFFF);

    // R10: reset in the middle of a transfer
    req_valid = 1'b1; req_src = 32'h100; req_dst = 32'h200; req_len = 16'd2000;
    @(negedge clk);
    req_valid = 1'b0; bst_ready = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!bst_valid && req_ready, "R10", "mid-transfer reset", 32'(bst_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule